// File: doc/BRIEF.md
# Prioritized Maskable Interrupt Controller

This block gathers interrupt request lines from peripheral devices (a timer, a network interface and similar), adds one request line that software sets and clears through register writes, and forwards at most one of them to the processor. Each maskable line passes through an individual enable bit, a global disable flag driven by the processor and a priority floor that the running handler raises. A fixed-priority encoder then picks the highest-indexed line that survives these gates. One non-maskable line bypasses every gate and always wins.

The processor sees a single interrupt line and an identity code, and both follow the request inputs combinationally. Software programs the enable bits, the priority floor and the software request through a small write port. It can observe the unfiltered request lines on a read-back output.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After synchronous reset all enable bits are 0, the priority floor is 0 and the software request is 0, so no maskable request raises `irq`.
- R2: A maskable line whose enable bit is 0 never raises `irq` and is never reported on `irq_id`.
- R3: Among eligible maskable lines, the one with the highest index wins, and `irq_id` equals its index. Device line k has index k, and the software request has index NUM_SRC.
- R4: A write with `wr_sel`=2 loads `wr_data[0]` into the software request. 1 sets it and 0 clears it, and the new value takes effect from the cycle after the write.
- R5: While `cpu_int_off` is 1, no maskable line raises `irq`.
- R6: While `nmi_req` is 1, `irq` is 1 and `irq_id` equals NUM_SRC+1, whatever the enable bits, the floor or `cpu_int_off` are.
- R7: Line index i has priority level i+1. It is eligible only when i+1 is strictly greater than the priority floor, which is written with `wr_sel`=1 from `wr_data[LW-1:0]`, so an equal or lower level is blocked.
- R8: `irq` and `irq_id` change in the same cycle as the request inputs, with no register between them.
- R9: `pend_raw` shows the unfiltered requests. Bits 0 to NUM_SRC-1 are the device lines and bit NUM_SRC is the software request.
- R10: A write with `wr_sel`=3 changes no state. A write with `wr_sel`=0 loads the enable bits from `wr_data`, with bit i enabling index i.
- R11: When `irq` is 0, `irq_id` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_req | input | NUM_SRC | Device request lines |
| nmi_req | input | 1 | Non-maskable request |
| cpu_int_off | input | 1 | Global disable for maskable requests |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 enables, 1 floor, 2 software request, 3 none |
| wr_data | input | NUM_SRC+1 | Write data |
| irq | output | 1 | Interrupt to the processor |
| irq_id | output | IDW | Identity of the winning request |
| pend_raw | output | NUM_SRC+1 | Unfiltered request lines |

## Verification
Request patterns with two separated active lines, such as indices 0 and 5 or 2 and 3, show whether the encoder favours the higher index or the lower one. Each pattern is applied with no clock edge before the sample, which exposes any registered path in the outputs. The floor is set both equal to a line's level and one below it, and this tells a strict comparison from an inclusive one. The non-maskable line is raised with everything else closed, and this separates a real bypass from a path that merely ranks highest.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

    typedef enum logic [1:0] {
        SEL_ENABLE = 2'd0,
        SEL_FLOOR  = 2'd1,
        SEL_SOFT   = 2'd2,
        SEL_NONE   = 2'd3
    } wr_target_e;

    // priority level carried by maskable line index idx
    function automatic int unsigned line_level(input int unsigned idx);
        return idx + 1;
    endfunction

endpackage

// File: rtl/irq_prio_regs.sv
module irq_prio_regs
    import irq_prio_pkg::*;
#(
    parameter int NL = 7,
    parameter int LW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  wr_target_e    wr_sel,
    input  logic [NL-1:0] wr_data,
    output logic [NL-1:0] enable_q,
    output logic [LW-1:0] floor_q,
    output logic          soft_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            enable_q <= '0;
            floor_q  <= '0;
            soft_q   <= 1'b0;
        end else if (wr_en) begin
            unique case (wr_sel)
                SEL_ENABLE: enable_q <= wr_data;
                SEL_FLOOR:  floor_q  <= wr_data[LW-1:0];
                SEL_SOFT:   soft_q   <= wr_data[0];
                default: ;
            endcase
        end
    end

    // R4: the software request follows the written bit
    p_soft_load_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == SEL_SOFT) |=> (soft_q == $past(wr_data[0])));

    // R10: idle or no-target writes leave all state alone
    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (!wr_en || wr_sel == SEL_NONE) |=>
            ($stable(enable_q) && $stable(floor_q) && $stable(soft_q)));

endmodule

// File: rtl/irq_prio_gate.sv
module irq_prio_gate
    import irq_prio_pkg::*;
#(
    parameter int NL = 7,
    parameter int LW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NL-1:0] req,
    input  logic [NL-1:0] enable_q,
    input  logic [LW-1:0] floor_q,
    input  logic          cpu_int_off,
    output logic [NL-1:0] elig
);

    for (genvar i = 0; i < NL; i++) begin : g_line
        logic above_floor;
        assign above_floor = (line_level(i) > int'(floor_q));
        assign elig[i] = req[i] & enable_q[i] & above_floor & ~cpu_int_off;
    end

    // R2: nothing disabled reaches the encoder
    p_enable_gate_r2: assert property (@(posedge clk) disable iff (rst)
        ((elig & ~enable_q) == '0));

    // R5: global disable empties the eligible set
    p_global_off_r5: assert property (@(posedge clk) disable iff (rst)
        cpu_int_off |-> (elig == '0));

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
    parameter int NL  = 7,
    parameter int IDW = 3
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NL-1:0]  elig,
    output logic           hit,
    output logic [IDW-1:0] win_id
);

    always_comb begin
        hit    = 1'b0;
        win_id = '0;
        for (int i = 0; i < NL; i++) begin
            if (elig[i]) begin
                hit    = 1'b1;
                win_id = IDW'(i);
            end
        end
    end

    // R3: the winner is an eligible line and no eligible line sits above it
    p_win_valid_r3: assert property (@(posedge clk) disable iff (rst)
        hit |-> elig[win_id]);
    p_no_higher_r3: assert property (@(posedge clk) disable iff (rst)
        hit |-> (((elig >> win_id) >> 1) == '0));

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_prio_pkg::*;
#(
    parameter int NUM_SRC = 6,
    parameter int NL      = NUM_SRC + 1,
    parameter int IDW     = $clog2(NUM_SRC + 2)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] dev_req,
    input  logic               nmi_req,
    input  logic               cpu_int_off,
    input  logic               wr_en,
    input  logic [1:0]         wr_sel,
    input  logic [NL-1:0]      wr_data,
    output logic               irq,
    output logic [IDW-1:0]     irq_id,
    output logic [NL-1:0]      pend_raw
);

    localparam int LW = IDW;
    localparam logic [IDW-1:0] NMI_ID = IDW'(NL);

    logic [NL-1:0]  enable_q;
    logic [LW-1:0]  floor_q;
    logic           soft_q;
    logic [NL-1:0]  req_all;
    logic [NL-1:0]  elig;
    logic           enc_hit;
    logic [IDW-1:0] enc_id;
    wr_target_e     sel_t;

    assign sel_t   = wr_target_e'(wr_sel);
    assign req_all = {soft_q, dev_req};

    irq_prio_regs #(.NL(NL), .LW(LW)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_sel   (sel_t),
        .wr_data  (wr_data),
        .enable_q (enable_q),
        .floor_q  (floor_q),
        .soft_q   (soft_q)
    );

    irq_prio_gate #(.NL(NL), .LW(LW)) u_gate (
        .clk         (clk),
        .rst         (rst),
        .req         (req_all),
        .enable_q    (enable_q),
        .floor_q     (floor_q),
        .cpu_int_off (cpu_int_off),
        .elig        (elig)
    );

    irq_prio_enc #(.NL(NL), .IDW(IDW)) u_enc (
        .clk    (clk),
        .rst    (rst),
        .elig   (elig),
        .hit    (enc_hit),
        .win_id (enc_id)
    );

    always_comb begin
        if (nmi_req) begin
            irq    = 1'b1;
            irq_id = NMI_ID;
        end else if (enc_hit) begin
            irq    = 1'b1;
            irq_id = enc_id;
        end else begin
            irq    = 1'b0;
            irq_id = '0;
        end
    end

    assign pend_raw = req_all;

    // R6: non-maskable request always surfaces with its own identity
    p_nmi_pass_r6: assert property (@(posedge clk) disable iff (rst)
        nmi_req |-> (irq && irq_id == NMI_ID));

    // R5: global disable blocks the processor line unless non-maskable
    p_off_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        (cpu_int_off && !nmi_req) |-> !irq);

    // R11: identity is zero when idle
    p_idle_id_r11: assert property (@(posedge clk) disable iff (rst)
        !irq |-> (irq_id == '0));

endmodule

// File: tb/irq_prio_ctrl_test.sv
`timescale 1ns/1ps
module irq_prio_ctrl_test;

    localparam int NUM_SRC = 6;
    localparam int NL      = NUM_SRC + 1;
    localparam int IDW     = $clog2(NUM_SRC + 2);

    logic               clk = 1'b0;
    logic               rst;
    logic [NUM_SRC-1:0] dev_req;
    logic               nmi_req;
    logic               cpu_int_off;
    logic               wr_en;
    logic [1:0]         wr_sel;
    logic [NL-1:0]      wr_data;
    logic               irq;
    logic [IDW-1:0]     irq_id;
    logic [NL-1:0]      pend_raw;

    irq_prio_ctrl #(.NUM_SRC(NUM_SRC)) uut (
        .clk(clk), .rst(rst), .dev_req(dev_req), .nmi_req(nmi_req),
        .cpu_int_off(cpu_int_off), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .irq(irq), .irq_id(irq_id), .pend_raw(pend_raw)
    );

    always #4 clk = ~clk;

    typedef struct {
        logic           irq;
        logic [IDW-1:0] id;
        logic [NL-1:0]  pend;
        string          tag;
    } exp_t;

    exp_t q[$];
    event ev_chk;
    int   n_run  = 0;
    int   n_fail = 0;
    bit   done   = 0;

    // bench-side view of programmed state, set from the requirements
    logic [NL-1:0] m_en;
    int            m_floor;
    logic          m_soft;

    function automatic exp_t predict(string tag);
        exp_t e;
        logic [NL-1:0] rq;
        rq     = {m_soft, dev_req};
        e.irq  = 1'b0;
        e.id   = '0;
        e.pend = rq;
        e.tag  = tag;
        if (nmi_req) begin
            e.irq = 1'b1;
            e.id  = IDW'(NL);
        end else if (!cpu_int_off) begin
            for (int i = 0; i < NL; i++)
                if (rq[i] && m_en[i] && (i + 1 > m_floor)) begin
                    e.irq = 1'b1;
                    e.id  = IDW'(i);
                end
        end
        return e;
    endfunction

    task automatic expect_now(string tag);
        #1;
        q.push_back(predict(tag));
        ->ev_chk;
        #0;
    endtask

    task automatic write_reg(input logic [1:0] sel, input logic [NL-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        case (sel)
            2'd0: m_en = d;
            2'd1: m_floor = int'(d[IDW-1:0]);
            2'd2: m_soft = d[0];
            default: ;
        endcase
    endtask

    task automatic set_in(input logic [NUM_SRC-1:0] d, input logic n, input logic off);
        @(negedge clk);
        dev_req = d; nmi_req = n; cpu_int_off = off;
    endtask

    // monitor: pops expected items and compares with the outputs
    initial begin
        forever begin
            @(ev_chk);
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                n_run++;
                if (irq !== e.irq || irq_id !== e.id || pend_raw !== e.pend) begin
                    n_fail++;
                    $display("FAIL %s: irq=%0b id=%0d pend=%b expected irq=%0b id=%0d pend=%b",
                             e.tag, irq, irq_id, pend_raw, e.irq, e.id, e.pend);
                end
            end
        end
    end

    initial begin
        rst = 1'b1; dev_req = '1; nmi_req = 0; cpu_int_off = 0;
        wr_en = 0; wr_sel = 0; wr_data = '0;
        m_en = '0; m_floor = 0; m_soft = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        expect_now("R1 reset state, R9 raw lines visible");

        write_reg(2'd0, '1);
        set_in(6'b000101, 0, 0);
        expect_now("R3 higher index 2 beats 0, R10 enable write");
        set_in(6'b100001, 0, 0);
        expect_now("R8 same-cycle change, R3 index 5 wins");

        write_reg(2'd0, 7'b1011111);
        expect_now("R2 disabled line 5 skipped");
        set_in(6'b100000, 0, 0);
        expect_now("R2 only disabled line requesting");

        write_reg(2'd0, '1);
        set_in(6'b000000, 0, 0);
        expect_now("R11 idle identity zero");

        write_reg(2'd2, 7'b0000001);
        expect_now("R4 software request set, R9 bit NUM_SRC");
        write_reg(2'd1, 7'd6);
        expect_now("R7 software level 7 above floor 6");
        write_reg(2'd1, 7'd7);
        expect_now("R7 floor 7 blocks all maskable");

        write_reg(2'd3, '1);
        set_in(6'b000100, 0, 0);
        expect_now("R10 no-target write keeps floor and enables");

        write_reg(2'd2, 7'b0000000);
        write_reg(2'd1, 7'd3);
        set_in(6'b001100, 0, 0);
        expect_now("R7 line 3 level 4 above floor 3");
        set_in(6'b000100, 0, 0);
        expect_now("R7 line 2 equal level blocked");
        expect_now("R4 software request cleared");

        write_reg(2'd1, 7'd0);
        set_in(6'b111111, 0, 1);
        expect_now("R5 global disable suppresses all");
        set_in(6'b111111, 1, 1);
        expect_now("R6 nmi through global disable");
        write_reg(2'd0, '0);
        write_reg(2'd1, 7'd7);
        set_in(6'b000000, 1, 0);
        expect_now("R6 nmi with enables off and floor max");
        set_in(6'b000000, 0, 0);
        expect_now("R6 nmi released, R11 idle");

        @(negedge clk);
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule